// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Protection Faults

This block translates 32-bit virtual addresses to physical addresses for 8 KB pages. It keeps two separate arrays, one for instruction fetches and one for data loads and stores. Each array has four ways at each of sixteen indices. A lookup takes a virtual address, an access type, a user-mode flag and a debug flag. It compares all four ways at the addressed index against the virtual page and the current 8-bit process ID. It then runs the enabled protection checks in a fixed priority. One cycle later it returns a physical address, a permission set and an exception vector number.

When a lookup faults and is not a debug probe, the block records the fault for a software refill handler. A select register names the way and index to refill, and a cause register records the faulting page, the process ID and the access kind. A 16-bit shift register then advances. Its low bits choose the victim way on the next miss. Software fills entries through a write port that takes a side, a way, an index and the two entry words.

Top module: `xlate_tlb`

## Requirements
- R1: The virtual page is vaddr[31:13] and the index is vaddr[16:13]. All four ways at that index of the chosen array are compared, and the lowest-numbered matching way supplies the entry. A successful lookup returns rsp_paddr = {entry low word [31:13], vaddr[12:0]}.
- R2: A way matches when its high word [31:13] equals the virtual page and either its low-word bit 4 (global) is set or its high word [7:0] equals pid. req_type encodes load = 0, store = 1, fetch = 2, and 3 is treated as a load. Fetches use the instruction array (wr_side = 0); all other types use the data array (wr_side = 1).
- R3: A lookup that matches no way faults with vector base+0. The base is 4 on the instruction side and 8 on the data side.
- R4: On a match, faults are taken in this priority. (1) cfg[18] set, entry bit 2 (kernel) set and req_user set gives base+2. (2) A store with cfg[19] set and entry bit 1 (writable) clear gives base+3. (3) A fetch with cfg[17] set and entry bit 0 (executable) clear gives base+3. (4) cfg[16] set and entry bit 3 (valid) clear gives base+1. Any other cfg bit has no effect.
- R5: rsp_perm is {exec, write, read}. On a successful lookup, read is 1 and write equals the entry writable bit. Exec is 1 only on the instruction side, and there only when cfg[17] or the entry executable bit is set. On a fault, rsp_perm and rsp_paddr are zero.
- R6: lfsr_state resets to 0xCCCC. Each step shifts it right by one and places bit0 ^ bit2 ^ bit11 ^ bit15 into bit 15. It steps exactly once for each faulting lookup with req_debug clear, and at no other time.
- R7: On each faulting lookup with req_debug clear, sel_reg becomes {way in [5:4], index in [3:0]} with all other bits zero. On a miss the way is lfsr_state[1:0] taken before the step. On a protection fault it is the matching way.
- R8: On the same event, cause_reg[7:0] takes pid and cause_reg[9:8] takes the access cause (read = 0, write = 1, execute = 2). cause_reg[31:13] takes the virtual page, and bits [12:10] keep their value.
- R9: A lookup with req_debug set still returns a response but leaves lfsr_state, sel_reg and cause_reg unchanged.
- R10: The response (rsp_valid and the other rsp_* outputs) appears on the clock edge that follows the request. A write lands in one cycle. After reset, every entry word is zero, rsp_valid is 0, sel_reg and cause_reg are zero, and lfsr_state is 0xCCCC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Array to write: 0 instruction, 1 data |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Index to write |
| wr_hi | input | 32 | Entry high word (page, process ID) |
| wr_lo | input | 32 | Entry low word (frame, flags) |
| cfg | input | 32 | Check enables in bits 19..16 |
| pid | input | 8 | Current process ID |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | Access type |
| req_user | input | 1 | User-mode access |
| req_debug | input | 1 | Probe with no state update |
| rsp_valid | output | 1 | Registered result valid |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | {exec, write, read} granted |
| rsp_vector | output | 4 | Exception vector number |
| sel_reg | output | 32 | Refill way and index |
| cause_reg | output | 32 | Fault cause record |
| lfsr_state | output | 16 | Victim-choice shift register |

## Verification
A corrupted entry word or a wrong way choice shows up at the ports on the next lookup of that index, one cycle after the request: the fault flag, the vector or the physical frame is wrong. A shift register that skips or repeats a step is visible on lfsr_state at once. A wrong step also sends the next miss to the wrong victim way in sel_reg. Because every later value follows from the seed, the error keeps showing on each later fault. A debug probe that leaks state is caught on the very next edge as a change in sel_reg, cause_reg or lfsr_state.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int CFG_WCHK = 19;
  localparam int CFG_KCHK = 18;
  localparam int CFG_XCHK = 17;
  localparam int CFG_VCHK = 16;

  localparam int LO_G = 4;
  localparam int LO_V = 3;
  localparam int LO_K = 2;
  localparam int LO_W = 1;
  localparam int LO_X = 0;

  typedef enum logic [1:0] {
    VOFF_MISS    = 2'd0,
    VOFF_INVALID = 2'd1,
    VOFF_KERNEL  = 2'd2,
    VOFF_RIGHTS  = 2'd3
  } voff_e;

  function automatic logic [15:0] lfsr_advance(input logic [15:0] s);
    return {s[15] ^ s[11] ^ s[2] ^ s[0], s[15:1]};
  endfunction

  function automatic logic [1:0] cause_code(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return 2'd2;
      ACC_STORE: return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] vector_of(input logic instr_side, input voff_e off);
    return (instr_side ? 4'd4 : 4'd8) + {2'b00, off};
  endfunction

endpackage

// File: rtl/xlate_way_array.sv
module xlate_way_array #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [31:0]                   wr_hi,
  input  logic [31:0]                   wr_lo,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [NUM_WAYS-1:0][31:0]     rd_hi,
  output logic [NUM_WAYS-1:0][31:0]     rd_lo
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [31:0] hi_mem [NUM_SETS];
    logic [31:0] lo_mem [NUM_SETS];
    logic        way_wr;

    assign way_wr = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_SETS; i++) begin
          hi_mem[i] <= '0;
          lo_mem[i] <= '0;
        end
      end else if (way_wr) begin
        hi_mem[wr_idx] <= wr_hi;
        lo_mem[wr_idx] <= wr_lo;
      end
    end

    assign rd_hi[w] = hi_mem[rd_idx];
    assign rd_lo[w] = lo_mem[rd_idx];
  end

endmodule

// File: rtl/xlate_way_match.sv
module xlate_way_match
  import xlate_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int VPN_W = 32 - PAGE_BITS
) (
  input  logic [NUM_WAYS-1:0][31:0] ent_hi,
  input  logic [NUM_WAYS-1:0][31:0] ent_lo,
  input  logic [VPN_W-1:0]          vpage,
  input  logic [PID_W-1:0]          cur_pid,
  output logic [NUM_WAYS-1:0]       cand_vec,
  output logic [NUM_WAYS-1:0]       win_vec,
  output logic                      hit,
  output logic [WAY_W-1:0]          win_way,
  output logic [31:0]               win_lo
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    logic tag_eq, owner_ok;
    assign tag_eq   = ent_hi[w][31:PAGE_BITS] == vpage;
    assign owner_ok = ent_lo[w][LO_G] || (ent_hi[w][PID_W-1:0] == cur_pid);
    assign cand_vec[w] = tag_eq && owner_ok;
  end

  // Scan from the top way down so the lowest candidate is the last one kept.
  always_comb begin
    win_vec = '0;
    win_way = '0;
    win_lo  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (cand_vec[w]) begin
        win_vec    = '0;
        win_vec[w] = 1'b1;
        win_way    = WAY_W'(w);
        win_lo     = ent_lo[w];
      end
    end
  end

  assign hit = |cand_vec;

endmodule

// File: rtl/xlate_prot_check.sv
module xlate_prot_check
  import xlate_pkg::*;
(
  input  logic        hit,
  input  logic [31:0] ent_lo,
  input  logic [31:0] cfg,
  input  logic [1:0]  acc,
  input  logic        user,
  input  logic        instr_side,
  output logic        fault,
  output voff_e       off,
  output logic [2:0]  perm
);

  logic is_store, is_fetch;
  logic trip_kernel, trip_write, trip_exec, trip_valid;

  assign is_store = acc == ACC_STORE;
  assign is_fetch = acc == ACC_FETCH;

  assign trip_kernel = cfg[CFG_KCHK] && ent_lo[LO_K] && user;
  assign trip_write  = is_store && cfg[CFG_WCHK] && !ent_lo[LO_W];
  assign trip_exec   = is_fetch && cfg[CFG_XCHK] && !ent_lo[LO_X];
  assign trip_valid  = cfg[CFG_VCHK] && !ent_lo[LO_V];

  always_comb begin
    fault = 1'b1;
    off   = VOFF_MISS;
    perm  = '0;
    if (hit) begin
      if (trip_kernel)                  off = VOFF_KERNEL;
      else if (trip_write || trip_exec) off = VOFF_RIGHTS;
      else if (trip_valid)              off = VOFF_INVALID;
      else begin
        fault = 1'b0;
        perm  = {instr_side && (cfg[CFG_XCHK] || ent_lo[LO_X]), ent_lo[LO_W], 1'b1};
      end
    end
  end

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_SETS  = 16,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hCCCC,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int VPN_W = 32 - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_hi,
  input  logic [31:0]       wr_lo,
  input  logic [31:0]       cfg,
  input  logic [PID_W-1:0]  pid,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_type,
  input  logic              req_user,
  input  logic              req_debug,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic [3:0]        rsp_vector,
  output logic [31:0]       sel_reg,
  output logic [31:0]       cause_reg,
  output logic [15:0]       lfsr_state
);

  // Side 0 holds instruction entries, side 1 data entries.
  logic [1:0][NUM_WAYS-1:0][31:0] side_hi, side_lo;

  logic             lk_instr;
  logic [VPN_W-1:0] lk_vpage;
  logic [IDX_W-1:0] lk_idx;

  assign lk_instr = req_type == ACC_FETCH;
  assign lk_vpage = req_vaddr[31:PAGE_BITS];
  assign lk_idx   = lk_vpage[IDX_W-1:0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    xlate_way_array #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_arr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en && (wr_side == 1'(s))),
      .wr_way (wr_way),
      .wr_idx (wr_idx),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .rd_idx (lk_idx),
      .rd_hi  (side_hi[s]),
      .rd_lo  (side_lo[s])
    );
  end

  logic [NUM_WAYS-1:0][31:0] lk_hi, lk_lo;
  assign lk_hi = lk_instr ? side_hi[0] : side_hi[1];
  assign lk_lo = lk_instr ? side_lo[0] : side_lo[1];

  logic [NUM_WAYS-1:0] lk_cand_vec, lk_win_vec;
  logic                lk_hit;
  logic [WAY_W-1:0]    lk_win_way;
  logic [31:0]         lk_win_lo;

  xlate_way_match #(.NUM_WAYS(NUM_WAYS), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)) u_match (
    .ent_hi   (lk_hi),
    .ent_lo   (lk_lo),
    .vpage    (lk_vpage),
    .cur_pid  (pid),
    .cand_vec (lk_cand_vec),
    .win_vec  (lk_win_vec),
    .hit      (lk_hit),
    .win_way  (lk_win_way),
    .win_lo   (lk_win_lo)
  );

  logic       lk_fault;
  voff_e      lk_off;
  logic [2:0] lk_perm;

  xlate_prot_check u_prot (
    .hit        (lk_hit),
    .ent_lo     (lk_win_lo),
    .cfg        (cfg),
    .acc        (req_type),
    .user       (req_user),
    .instr_side (lk_instr),
    .fault      (lk_fault),
    .off        (lk_off),
    .perm       (lk_perm)
  );

  // Named events for the checker.
  logic lk_fault_evt, lk_commit;
  assign lk_fault_evt = req_valid && lk_fault;
  assign lk_commit    = lk_fault_evt && !req_debug;

  logic [15:0]      lfsr_q;
  logic [WAY_W-1:0] lk_rep_way;
  logic [31:0]      lk_paddr, sel_nxt, cause_nxt, sel_q, cause_q;

  assign lk_rep_way = lk_hit ? lk_win_way : lfsr_q[WAY_W-1:0];
  assign lk_paddr   = lk_fault ? 32'd0 : {lk_win_lo[31:PAGE_BITS], req_vaddr[PAGE_BITS-1:0]};

  always_comb begin
    sel_nxt = '0;
    sel_nxt[WAY_W+IDX_W-1:0] = {lk_rep_way, lk_idx};
    cause_nxt = cause_q;
    cause_nxt[31:PAGE_BITS] = lk_vpage;
    cause_nxt[9:8]          = cause_code(req_type);
    cause_nxt[PID_W-1:0]    = pid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_perm   <= '0;
      rsp_vector <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault  <= lk_fault;
        rsp_paddr  <= lk_paddr;
        rsp_perm   <= lk_perm;
        rsp_vector <= vector_of(lk_instr, lk_off);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= LFSR_SEED;
      sel_q   <= '0;
      cause_q <= '0;
    end else if (lk_commit) begin
      lfsr_q  <= lfsr_advance(lfsr_q);
      sel_q   <= sel_nxt;
      cause_q <= cause_nxt;
    end
  end

  assign lfsr_state = lfsr_q;
  assign sel_reg    = sel_q;
  assign cause_reg  = cause_q;

endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk
  import xlate_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SEL_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_debug,
  input logic [1:0]          req_type,
  input logic                lk_fault_evt,
  input logic [NUM_WAYS-1:0] win_vec,
  input logic                rsp_valid,
  input logic                rsp_fault,
  input logic [2:0]          rsp_perm,
  input logic [3:0]          rsp_vector,
  input logic [31:0]         sel_reg,
  input logic [31:0]         cause_reg,
  input logic [15:0]         lfsr_state
);

  assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  assert_instr_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == ACC_FETCH) |=> (!rsp_fault || (rsp_vector >= 4'd4 && rsp_vector <= 4'd7)));

  assert_data_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type != ACC_FETCH) |=> (!rsp_fault || (rsp_vector >= 4'd8 && rsp_vector <= 4'd11)));

  assert_fault_no_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_perm == 3'd0);

  assert_read_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_perm[0]);

  assert_lfsr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault_evt && !req_debug) |=> lfsr_state == lfsr_advance($past(lfsr_state)));

  assert_lfsr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_fault_evt && !req_debug) |=> $stable(lfsr_state));

  assert_sel_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reg[31:SEL_W] == '0);

  assert_debug_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_debug) |=> ($stable(sel_reg) && $stable(cause_reg) && $stable(lfsr_state)));

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_resp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

endmodule

bind xlate_tlb xlate_tlb_chk #(.NUM_WAYS(NUM_WAYS), .SEL_W(WAY_W + IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_debug    (req_debug),
  .req_type     (req_type),
  .lk_fault_evt (lk_fault_evt),
  .win_vec      (lk_win_vec),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_perm     (rsp_perm),
  .rsp_vector   (rsp_vector),
  .sel_reg      (sel_reg),
  .cause_reg    (cause_reg),
  .lfsr_state   (lfsr_state)
);

// File: tb/xlate_tlb_test.sv
module xlate_tlb_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0, cfg = '0;
  logic [7:0]  pid = '0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_debug = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, sel_reg, cause_reg;
  logic [2:0]  rsp_perm;
  logic [3:0]  rsp_vector;
  logic [15:0] lfsr_state;

  always #2 clk = ~clk;

  xlate_tlb uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the arrays and fault registers.
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [15:0] m_lfsr = 16'hCCCC;
  logic [31:0] m_sel = '0, m_cause = '0;
  logic        e_fault;
  logic [3:0]  e_vec;
  logic [31:0] e_paddr;
  logic [2:0]  e_perm;

  task automatic ck(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic fb = ^(s & 16'h8805);
    return (s >> 1) | {fb, 15'd0};
  endfunction

  task automatic predict(input logic [31:0] va, input logic [1:0] t, input logic u, input logic d);
    int side = (t == 2'd2) ? 0 : 1;
    logic [18:0] vp = va[31:13];
    int ix = int'(vp[3:0]);
    int hw = -1;
    logic [31:0] lo;
    logic [3:0] base = (side == 0) ? 4'd4 : 4'd8;
    logic [1:0] way;
    for (int k = 3; k >= 0; k--)
      if (m_hi[side][k][ix][31:13] == vp && (m_lo[side][k][ix][4] || m_hi[side][k][ix][7:0] == pid))
        hw = k;
    e_fault = 1'b1; e_perm = 3'd0; e_paddr = 32'd0; e_vec = base;
    way = m_lfsr[1:0];
    if (hw >= 0) begin
      lo = m_lo[side][hw][ix];
      way = 2'(hw);
      if (cfg[18] && lo[2] && u)                 e_vec = base + 4'd2;
      else if (t == 2'd1 && cfg[19] && !lo[1])   e_vec = base + 4'd3;
      else if (t == 2'd2 && cfg[17] && !lo[0])   e_vec = base + 4'd3;
      else if (cfg[16] && !lo[3])                e_vec = base + 4'd1;
      else begin
        e_fault = 1'b0;
        e_paddr = {lo[31:13], va[12:0]};
        e_perm  = {side == 0 && (cfg[17] || lo[0]), lo[1], 1'b1};
      end
    end
    if (e_fault && !d) begin
      m_sel   = {26'd0, way, vp[3:0]};
      m_cause = {vp, m_cause[12:10], (t == 2'd2) ? 2'd2 : (t == 2'd1) ? 2'd1 : 2'd0, pid};
      m_lfsr  = m_step(m_lfsr);
    end
  endtask

  task automatic tb_write(input logic s, input logic [1:0] w, input logic [3:0] i,
                          input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_side = s; wr_way = w; wr_idx = i; wr_hi = hi; wr_lo = lo;
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_hi[s][w][i] = hi;
    m_lo[s][w][i] = lo;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] t, input logic u, input logic d);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_type = t; req_user = u; req_debug = d;
    predict(va, t, u, d);
    @(posedge clk); #1;
    ck("R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    ck("R2", "fault flag", 32'(rsp_fault), 32'(e_fault));
    ck("R4", "vector", 32'(rsp_vector), 32'(e_vec));
    ck("R1", "paddr", rsp_paddr, e_paddr);
    ck("R5", "perm", 32'(rsp_perm), 32'(e_perm));
    ck(d ? "R9" : "R7", "sel_reg", sel_reg, m_sel);
    ck(d ? "R9" : "R8", "cause_reg", cause_reg, m_cause);
    ck(d ? "R9" : "R6", "lfsr", 32'(lfsr_state), 32'(m_lfsr));
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] p);
    return {vpn, 5'd0, p};
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] pids [2];
    logic [15:0] lf0;
    pids[0] = 8'h11; pids[1] = 8'h5A;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 16; i++) begin m_hi[s][w][i] = '0; m_lo[s][w][i] = '0; end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R10, R6)
    ck("R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    ck("R10", "reset sel_reg", sel_reg, 32'd0);
    ck("R10", "reset cause_reg", cause_reg, 32'd0);
    ck("R6", "reset lfsr", 32'(lfsr_state), 32'h0000CCCC);

    pid = 8'h11;
    cfg = 32'h000F_0000;
    // R3: instruction-side miss gives vector 4, victim way from lfsr[1:0]
    lookup({19'h00040, 13'h0123}, 2'd2, 1'b0, 1'b0);
    ck("R3", "instr miss vector", 32'(rsp_vector), 32'd4);
    ck("R7", "miss way from seed", 32'(sel_reg[5:4]), 32'd0);

    // R1: lowest matching way wins
    tb_write(1'b1, 2'd3, 4'h5, mk_hi(19'h00025, 8'h11), {19'h1AAAA, 13'h000A});
    tb_write(1'b1, 2'd1, 4'h5, mk_hi(19'h00025, 8'h11), {19'h0BBBB, 13'h000A});
    lookup({19'h00025, 13'h1FFF}, 2'd0, 1'b0, 1'b0);
    ck("R1", "lowest way frame", rsp_paddr, {19'h0BBBB, 13'h1FFF});

    // R2: global entry hits under another process ID
    tb_write(1'b1, 2'd2, 4'h7, mk_hi(19'h00017, 8'h77), {19'h00321, 13'h001A});
    lookup({19'h00017, 13'h0040}, 2'd0, 1'b1, 1'b0);
    ck("R2", "global hit", 32'(rsp_fault), 32'd0);

    // R4: kernel check outranks write check on a user store
    tb_write(1'b1, 2'd0, 4'h9, mk_hi(19'h00019, 8'h11), {19'h00001, 13'h000C});
    lookup({19'h00019, 13'h0000}, 2'd1, 1'b1, 1'b0);
    ck("R4", "kernel before write", 32'(rsp_vector), 32'd10);
    ck("R7", "fault way is hit way", 32'(sel_reg[5:0]), 32'h09);

    // R9: debug probe of a miss changes no state
    lf0 = lfsr_state;
    lookup({19'h00333, 13'h0000}, 2'd0, 1'b0, 1'b1);
    ck("R9", "debug lfsr hold", 32'(lfsr_state), 32'(lf0));

    // R5: fetch with execute check off still grants exec when entry allows
    cfg = 32'h0000_0000;
    tb_write(1'b0, 2'd2, 4'h3, mk_hi(19'h00013, 8'h11), {19'h00444, 13'h0001});
    lookup({19'h00013, 13'h0010}, 2'd2, 1'b0, 1'b0);
    ck("R5", "fetch perm", 32'(rsp_perm), 32'd5);

    // Random entries and lookups
    for (int n = 0; n < 120; n++) begin
      logic [18:0] vpn = 19'($urandom_range(0, 31));
      tb_write(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), vpn[3:0],
               mk_hi(vpn, pids[$urandom_range(0, 1)]),
               {19'($urandom), 8'd0, 5'($urandom)});
    end
    for (int n = 0; n < 3000; n++) begin
      if (n % 25 == 0) begin
        logic [18:0] vpn = 19'($urandom_range(0, 31));
        tb_write(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), vpn[3:0],
                 mk_hi(vpn, pids[$urandom_range(0, 1)]),
                 {19'($urandom), 8'd0, 5'($urandom)});
      end
      @(negedge clk);
      cfg = $urandom;
      pid = pids[$urandom_range(0, 1)];
      lookup({19'($urandom_range(0, 31)), 13'($urandom)}, 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end

    done = 1;
    finish_up();
  end

endmodule